// File: doc/BRIEF.md
# Serial EEPROM-Style Two-Wire Target

This block is a two-wire serial bus target that fronts a 256-byte storage array, behaving like a small non-volatile memory. SCL and SDA are oversampled by a faster system clock. The block finds bus START and STOP conditions and recognises its 7-bit device address. It accepts single-byte writes through an 8-bit word pointer. It answers reads by streaming bytes for as long as the bus master keeps acknowledging.

A write reaches the array only when the STOP that closes it arrives. That STOP starts a self-timed busy interval that imitates a programming cycle. For the whole interval the target stays silent on the bus and will not even answer its own address. SDA is driven open-drain: the block only ever pulls the line low. A busy flag is exported for the surrounding logic.

Top module: `i2c_nvm_target`

## Requirements
- R1: After reset SDA is released, busy is low, the word pointer is 0 and every array byte reads as 0x00.
- R2: After a START, a first byte whose upper seven bits equal DEV_ADDR (default 1010000, MSB first, R/W in bit 0) is acknowledged by pulling SDA low during the ninth SCL clock, provided busy is low.
- R3: A first byte with a different address gets no acknowledge, and the target leaves SDA released until the next START or STOP.
- R4: In a write (R/W = 0), the word-address byte is loaded into the pointer and acknowledged, then the single data byte is acknowledged.
- R5: A STOP that closes an acknowledged data byte stores the byte at the pointer. busy goes high on the third system clock after the SDA rise of the STOP and stays high for exactly PROG_CYCLES clocks.
- R6: While busy is high the target never pulls SDA low, so its own address gets no acknowledge.
- R7: A repeated START between the data byte and STOP discards the pending write: the array is unchanged and busy stays low.
- R8: In a read (R/W = 1) the target sends the byte at the pointer MSB first, then releases SDA for the ninth clock. The pointer advances by one after each byte sent.
- R9: A master that does not acknowledge (SDA high on the ninth clock) ends the read. Further SCL clocks leave SDA released until STOP or START.
- R10: A read with no preceding word-address byte starts at the current pointer. A completed write leaves the pointer at the written word address.
- R11: SDA drive changes only while the synchronised SCL is low.
- R12: The pointer wraps from 0xFF to 0x00 during a sequential read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (resolved wired-AND) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High during the programming interval |

## Verification
Both bus lines pass through two synchronising flops and a history flop. As a result, every change the target makes to SDA lands three system clocks after the SCL fall that triggers it. The bus model drives each bit with SCL phases four clocks long and reads SDA in the middle of the SCL-high phase, well after that change has settled. busy must rise on the third clock edge after the STOP's SDA rise. The bench's model arms a three-edge countdown at that moment, then holds its expected busy high for PROG_CYCLES edges. The DUT's busy is compared with this model one time unit after every falling clock edge, where no register is changing.

// File: rtl/i2c_nvm_pkg.sv
package i2c_nvm_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int BITCNT_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RX_ACK,
        S_TX,
        S_TX_ACK,
        S_WAIT
    } bus_st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } rx_phase_e;

    typedef struct packed {
        bus_st_e              st;
        rx_phase_e            ph;
        logic [BITCNT_W-1:0]  cnt;
        logic [DATA_W-1:0]    sh;
        logic [ADDR_W-1:0]    ptr;
        logic [DATA_W-1:0]    wdat;
        logic                 oe;
        logic                 rw;
        logic                 wpend;
        logic                 mack;
    } ctl_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '1;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) dprev <= '1;
        else        dprev <= dout;
    end

endmodule

// File: rtl/i2c_nvm_array.sv
module i2c_nvm_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/i2c_prog_timer.sv
module i2c_prog_timer #(
    parameter int CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/i2c_nvm_target.sv
module i2c_nvm_target
    import i2c_nvm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         PROG_CYCLES = 500,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    output logic busy_o
);

    logic [1:0] line_s, line_p;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic wr_en, prog_start;
    logic [DATA_W-1:0] rd_data;
    ctl_t ctl_d, ctl_q;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (line_s),
        .dprev (line_p)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];
    assign scl_p = line_p[1];
    assign sda_p = line_p[0];

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

    i2c_nvm_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (ctl_q.ptr),
        .wdata (ctl_q.wdat),
        .raddr (ctl_q.ptr),
        .rdata (rd_data)
    );

    i2c_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        wr_en      = 1'b0;
        prog_start = 1'b0;

        if (start_det) begin
            ctl_d.st    = S_RX;
            ctl_d.ph    = PH_DEV;
            ctl_d.cnt   = '0;
            ctl_d.oe    = 1'b0;
            ctl_d.wpend = 1'b0;
            ctl_d.mack  = 1'b0;
        end else if (stop_det) begin
            ctl_d.st    = S_IDLE;
            ctl_d.oe    = 1'b0;
            ctl_d.wpend = 1'b0;
            ctl_d.mack  = 1'b0;
            if (ctl_q.wpend) begin
                wr_en      = 1'b1;
                prog_start = 1'b1;
            end
        end else begin
            case (ctl_q.st)
                S_RX: begin
                    if (scl_rise && ctl_q.cnt != 4'd8) begin
                        ctl_d.sh  = {ctl_q.sh[DATA_W-2:0], sda_s};
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        ctl_d.cnt = '0;
                        case (ctl_q.ph)
                            PH_DEV: begin
                                if (ctl_q.sh[7:1] == DEV_ADDR && !busy_o) begin
                                    ctl_d.oe = 1'b1;
                                    ctl_d.rw = ctl_q.sh[0];
                                    ctl_d.st = S_RX_ACK;
                                end else begin
                                    ctl_d.st = S_WAIT;
                                end
                            end
                            PH_WORD: begin
                                ctl_d.ptr = ctl_q.sh;
                                ctl_d.oe  = 1'b1;
                                ctl_d.st  = S_RX_ACK;
                            end
                            default: begin
                                ctl_d.wdat  = ctl_q.sh;
                                ctl_d.wpend = 1'b1;
                                ctl_d.oe    = 1'b1;
                                ctl_d.st    = S_RX_ACK;
                            end
                        endcase
                    end
                end
                S_RX_ACK: begin
                    if (scl_fall) begin
                        ctl_d.oe  = 1'b0;
                        ctl_d.cnt = '0;
                        if (ctl_q.ph == PH_DEV && ctl_q.rw) begin
                            ctl_d.st = S_TX;
                            ctl_d.sh = rd_data;
                            ctl_d.oe = ~rd_data[DATA_W-1];
                        end else if (ctl_q.ph == PH_DATA) begin
                            ctl_d.st = S_WAIT;
                        end else begin
                            ctl_d.st = S_RX;
                            ctl_d.ph = (ctl_q.ph == PH_DEV) ? PH_WORD : PH_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (ctl_q.cnt == 4'd8) begin
                            ctl_d.oe  = 1'b0;
                            ctl_d.st  = S_TX_ACK;
                            ctl_d.ptr = ctl_q.ptr + 8'd1;
                            ctl_d.cnt = '0;
                        end else begin
                            ctl_d.sh = {ctl_q.sh[DATA_W-2:0], 1'b0};
                            ctl_d.oe = ~ctl_q.sh[DATA_W-2];
                        end
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) ctl_d.st   = S_WAIT;
                        else       ctl_d.mack = 1'b1;
                    end else if (scl_fall && ctl_q.mack) begin
                        ctl_d.mack = 1'b0;
                        ctl_d.st   = S_TX;
                        ctl_d.sh   = rd_data;
                        ctl_d.oe   = ~rd_data[DATA_W-1];
                    end
                end
                default: begin
                    ctl_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, ph: PH_DEV, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o = ctl_q.oe;

endmodule

// File: rtl/i2c_nvm_target_chk.sv
module i2c_nvm_target_chk #(
    parameter int PROG_CYCLES = 500
) (
    input logic clk,
    input logic rst_n,
    input logic sda_oe,
    input logic busy_o,
    input logic scl_s,
    input logic stop_det,
    input logic prog_start
);

    int busy_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          busy_len_q <= 0;
        else if (prog_start) busy_len_q <= 0;
        else if (busy_o)     busy_len_q <= busy_len_q + 1;
    end

    a_r1_reset_values: assert property (@(posedge clk)
        $rose(rst_n) |-> (!sda_oe && !busy_o));

    a_r11_oe_moves_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    a_r6_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe);

    a_r5_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy_o);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == PROG_CYCLES));

    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind i2c_nvm_target i2c_nvm_target_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_oe     (sda_oe_o),
    .busy_o     (busy_o),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .prog_start (prog_start)
);

// File: tb/i2c_nvm_target_tb.sv
module i2c_nvm_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int PROG       = 300;
    localparam logic [7:0] WR_BYTE = 8'hA0;
    localparam logic [7:0] RD_BYTE = 8'hA1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, busy;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2c_nvm_target #(.PROG_CYCLES(PROG)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .busy_o   (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit run = 0;
    int arm = 0;
    int left = 0;
    int m_mem [256];
    int m_ptr = 0;
    bit m_wpend = 0;
    int m_wdat = 0;
    int glitches = 0;
    int hi_run = 0;
    logic prev_oe = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // behavioural busy model: three edges of latency, then PROG edges high
    always @(posedge clk) begin
        if (arm > 0) begin
            arm--;
            if (arm == 0) left = PROG;
        end else if (left > 0) begin
            left--;
        end
    end

    always @(negedge clk) begin
        #1;
        if (run) begin
            chk(busy == (left != 0), "R5 busy trace", int'(busy), int'(left != 0));
            if (hi_run >= 3 && sda_oe !== prev_oe) glitches++;
            hi_run  = scl_m ? hi_run + 1 : 0;
            prev_oe = sda_oe;
        end
    end

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; m_wpend = 0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bstop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1;
        if (m_wpend) begin
            arm = 3;
            m_mem[m_ptr] = m_wdat;
        end
        m_wpend = 0;
        qw(); qw();
    endtask

    task automatic bbit(input logic b, output logic r);
        sda_m = b; qw();
        scl_m = 1'b1; qw();
        r = sda_line; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) bbit(d[i], r);
        bbit(1'b1, r);
        ack = !r;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bbit(1'b1, r);
            d[i] = r;
        end
        bbit(!give_ack, r);
        m_ptr = (m_ptr + 1) % 256;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] v);
        bit ack;
        bstart();
        wbyte(WR_BYTE, ack); chk(ack, "R2 address ack", int'(ack), 1);
        wbyte(a, ack);       chk(ack, "R4 word ack", int'(ack), 1);
        m_ptr = a;
        wbyte(v, ack);       chk(ack, "R4 data ack", int'(ack), 1);
        m_wdat = v; m_wpend = 1;
        bstop();
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        qw();
    endtask

    task automatic set_ptr(input logic [7:0] a);
        bit ack;
        bstart();
        wbyte(WR_BYTE, ack); chk(ack, "R2 address ack", int'(ack), 1);
        wbyte(a, ack);       chk(ack, "R4 word ack", int'(ack), 1);
        m_ptr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        bit ack;
        logic [7:0] d;
        logic r;
        int quiet;
        for (int i = 0; i < 256; i++) m_mem[i] = 0;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
        chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
        rst_n = 1'b1;
        run = 1;
        qw();
        chk(sda_oe == 1'b0 && busy == 1'b0, "R1 idle after reset", int'({sda_oe, busy}), 0);

        // R4/R5: byte write then NACK while programming (R6)
        do_write(8'h10, 8'hA5);
        bstart();
        wbyte(WR_BYTE, ack);
        chk(!ack, "R6 own address while busy", int'(ack), 0);
        chk(busy == 1'b1, "R6 busy during probe", int'(busy), 1);
        bstop();
        wait_idle();

        do_write(8'hFF, 8'h3C); wait_idle();
        do_write(8'h00, 8'hC3); wait_idle();
        do_write(8'h02, 8'h5A); wait_idle();

        // R3: wrong address, then a full byte with the line left to the target
        bstart();
        wbyte(8'hA2, ack);
        chk(!ack, "R3 mismatched address nack", int'(ack), 0);
        wbyte(8'hFF, ack);
        chk(!ack, "R3 silent after mismatch", int'(ack), 0);
        bstop();

        // R7: write aborted by repeated START
        set_ptr(8'h40);
        wbyte(8'h77, ack);
        chk(ack, "R4 data ack", int'(ack), 1);
        m_wdat = 8'h77; m_wpend = 1;
        bstart();
        wbyte(WR_BYTE, ack);
        chk(ack, "R7 restart address ack", int'(ack), 1);
        bstop();
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R7 no busy after abort", int'(busy), 0);

        // R8/R12: random read from 0xFF across the wrap
        set_ptr(8'hFF);
        bstart();
        wbyte(RD_BYTE, ack);
        chk(ack, "R2 read address ack", int'(ack), 1);
        rbyte(1, d); chk(d == 8'h3C, "R8 first read byte", int'(d), 'h3C);
        rbyte(1, d); chk(d == 8'hC3, "R12 wrapped read byte", int'(d), 'hC3);
        rbyte(0, d); chk(d == m_mem[1], "R8 third read byte", int'(d), m_mem[1]);
        // R9: after master NACK the target stays off the line
        quiet = 0;
        for (int i = 0; i < 9; i++) begin
            bbit(1'b1, r);
            if (r == 1'b1) quiet++;
        end
        chk(quiet == 9, "R9 released after master nack", quiet, 9);
        bstop();

        // R10: current-address read continues at pointer 0x02
        bstart();
        wbyte(RD_BYTE, ack);
        rbyte(0, d);
        chk(d == 8'h5A, "R10 current address read", int'(d), 'h5A);
        bstop();

        // R7: aborted byte never reached the array
        set_ptr(8'h40);
        bstart();
        wbyte(RD_BYTE, ack);
        rbyte(0, d);
        chk(d == 8'h00, "R7 aborted write absent", int'(d), 0);
        bstop();

        // R10: write leaves pointer on the word address
        do_write(8'h30, 8'h99); wait_idle();
        bstart();
        wbyte(RD_BYTE, ack);
        rbyte(0, d);
        chk(d == 8'h99, "R10 pointer after write", int'(d), 'h99);
        bstop();

        // R1: untouched cell reads as zero
        set_ptr(8'h80);
        bstart();
        wbyte(RD_BYTE, ack);
        rbyte(0, d);
        chk(d == 8'h00, "R1 reset contents", int'(d), 0);
        bstop();

        qw();
        chk(glitches == 0, "R11 drive changes with SCL high", glitches, 0);
        summary();
    end

endmodule